// File: doc/BRIEF.md
# Unified Reservation Station Scheduler

This block holds decoded instructions for a single-issue out-of-order core until their operands are available. It then hands them to one of two execution units. It has four interchangeable stations, and each one can hold either a multiply or a general arithmetic instruction. Each station carries the destination reorder-buffer tag and two source operands. A source operand is either a captured value or a pending 3-bit tag.

A single result bus is snooped every cycle. When a broadcast tag matches a pending source, the station copies the value, and the station becomes eligible for selection in the following cycle. Each cycle the scheduler picks the oldest eligible multiply instruction and the oldest eligible non-multiply instruction, in program order. It asserts the matching start strobe together with the tag and operands. A station is released in the cycle it is picked, and an issue in that same cycle may land in it.

Each station is a three-state machine:
- `ST_FREE` moves to `ST_WAIT` when it is filled with a pending source.
- `ST_FREE` moves to `ST_READY` when it is filled with both sources known.
- `ST_WAIT` moves to `ST_READY` when the last pending source is captured.
- `ST_READY` moves to `ST_FREE` when it is picked.
- `ST_READY` moves to `ST_WAIT` or `ST_READY` when it is picked and refilled in the same cycle.

Top module: `rs_sched`

## Requirements
- R1: After reset all stations are free: `iss_ready`=1, `pool_full`=0, `mul_go`=0, `alu_go`=0.
- R2: An instruction is taken only in a cycle with `iss_valid` and `iss_ready` both high, at most one per cycle. `iss_ready` is low when all four stations are occupied and none is picked in that cycle. An instruction offered while `iss_ready` is low is dropped and never dispatched.
- R3: Any station can hold either class (`iss_mul`=1 for multiply, 0 otherwise). `pool_full` is 1 exactly when all four stations are occupied.
- R4: An instruction issued with both sources present starts no earlier than the next cycle. With no contention, it starts in that next cycle.
- R5: A source pending on tag T becomes usable in the cycle after `bc_valid` is seen with `bc_tag`=T. The instruction never starts in the broadcast cycle itself.
- R6: If a broadcast matches a pending source in the same cycle the instruction is issued, the broadcast value is captured.
- R7: Among eligible instructions for the same unit, the one issued earliest wins, regardless of which station it occupies.
- R8: `mul_go` is asserted only while `mul_idle` is 1. A ready multiply waits until then.
- R9: A station is freed in the cycle it is picked. With a full pool, `iss_ready` is 1 in that cycle and the new instruction is accepted into the freed station.
- R10: One multiply and one non-multiply instruction may start in the same cycle.
- R11: Each start strobe presents the instruction's destination tag and both operand values on its unit's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_ready | output | 1 | A station is free or being freed this cycle |
| iss_mul | input | 1 | 1 = multiply class, 0 = other |
| iss_dst | input | 3 | Destination reorder-buffer tag |
| iss_a_rdy | input | 1 | Source A value present |
| iss_a_tag | input | 3 | Source A producer tag when pending |
| iss_a_val | input | 32 | Source A value when present |
| iss_b_rdy | input | 1 | Source B value present |
| iss_b_tag | input | 3 | Source B producer tag when pending |
| iss_b_val | input | 32 | Source B value when present |
| bc_valid | input | 1 | Result broadcast this cycle |
| bc_tag | input | 3 | Tag of the broadcast result |
| bc_data | input | 32 | Broadcast result value |
| pool_full | output | 1 | All four stations occupied |
| mul_idle | input | 1 | Multiply unit can accept a new operation |
| mul_go | output | 1 | Start strobe for the multiply unit |
| mul_dst | output | 3 | Destination tag of the started multiply |
| mul_a | output | 32 | Operand A of the started multiply |
| mul_b | output | 32 | Operand B of the started multiply |
| alu_go | output | 1 | Start strobe for the pipelined unit |
| alu_dst | output | 3 | Destination tag of the started instruction |
| alu_a | output | 32 | Operand A |
| alu_b | output | 32 | Operand B |

## Verification
Picking a station and issuing into the same station can happen in one cycle. This is provoked by filling the pool with multiplies while `mul_idle` is low, then raising `mul_idle` in the same cycle that a new instruction is offered. The check is that `iss_ready` stays high, the oldest multiply starts, and the newcomer starts one cycle later. A broadcast that coincides with an issue is also driven: the value must appear on the unit's operand output in the next cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
    parameter int TAG_W  = 3;
    parameter int DATA_W = 32;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } rs_src_t;

    typedef struct packed {
        logic             is_mul;
        logic [TAG_W-1:0] dst;
        rs_src_t          a;
        rs_src_t          b;
    } rs_op_t;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } rs_state_e;

    function automatic rs_src_t rs_snoop(input rs_src_t s, input logic v,
                                         input logic [TAG_W-1:0] t,
                                         input logic [DATA_W-1:0] d);
        rs_src_t r;
        r = s;
        if (!s.rdy && v && (s.tag == t)) begin
            r.rdy = 1'b1;
            r.val = d;
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  rs_op_t            alloc_op,
    input  logic              pick,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output rs_state_e         state,
    output logic              is_mul,
    output logic [TAG_W-1:0]  dst,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);
    rs_state_e state_q, state_d;
    rs_op_t    op_q, op_d;

    // operand capture: new entry or snoop of a held one
    always_comb begin
        op_d = op_q;
        if (alloc) begin
            op_d   = alloc_op;
            op_d.a = rs_snoop(alloc_op.a, bc_valid, bc_tag, bc_data);
            op_d.b = rs_snoop(alloc_op.b, bc_valid, bc_tag, bc_data);
        end else if (state_q != ST_FREE) begin
            op_d.a = rs_snoop(op_q.a, bc_valid, bc_tag, bc_data);
            op_d.b = rs_snoop(op_q.b, bc_valid, bc_tag, bc_data);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (alloc)
                    state_d = (op_d.a.rdy && op_d.b.rdy) ? ST_READY : ST_WAIT;
            end
            ST_WAIT: begin
                if (op_d.a.rdy && op_d.b.rdy)
                    state_d = ST_READY;
            end
            ST_READY: begin
                if (pick) begin
                    if (alloc)
                        state_d = (op_d.a.rdy && op_d.b.rdy) ? ST_READY : ST_WAIT;
                    else
                        state_d = ST_FREE;
                end
            end
            default: state_d = ST_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            op_q    <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
        end
    end

    // outputs
    always_comb begin
        state  = state_q;
        is_mul = op_q.is_mul;
        dst    = op_q.dst;
        a_val  = op_q.a.val;
        b_val  = op_q.b.val;
    end
endmodule

// File: rtl/rs_age_matrix.sv
module rs_age_matrix #(
    parameter int NUM_ST = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_ST-1:0]        alloc,
    output logic [NUM_ST*NUM_ST-1:0] older_flat
);
    // older_q[j][i] = 1 when station j was filled before station i
    logic [NUM_ST-1:0] older_q [NUM_ST];

    for (genvar j = 0; j < NUM_ST; j++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < NUM_ST; i++)
                    older_q[j][i] <= (j < i);
            end else begin
                for (int i = 0; i < NUM_ST; i++) begin
                    if (alloc[i])
                        older_q[j][i] <= (i != j);
                    else if (alloc[j])
                        older_q[j][i] <= 1'b0;
                end
            end
        end
        assign older_flat[j*NUM_ST +: NUM_ST] = older_q[j];
    end
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
    parameter int NUM_ST = 4
) (
    input  logic [NUM_ST-1:0]        cand,
    input  logic [NUM_ST*NUM_ST-1:0] older_flat,
    output logic [NUM_ST-1:0]        win
);
    for (genvar i = 0; i < NUM_ST; i++) begin : g_col
        logic blocked;
        always_comb begin
            blocked = 1'b0;
            for (int j = 0; j < NUM_ST; j++)
                if (cand[j] && older_flat[j*NUM_ST + i])
                    blocked = 1'b1;
        end
        assign win[i] = cand[i] && !blocked;
    end
endmodule

// File: rtl/rs_sched.sv
module rs_sched
    import rs_pkg::*;
#(
    parameter int NUM_ST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic              iss_mul,
    input  logic [TAG_W-1:0]  iss_dst,
    input  logic              iss_a_rdy,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic              iss_b_rdy,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              pool_full,
    input  logic              mul_idle,
    output logic              mul_go,
    output logic [TAG_W-1:0]  mul_dst,
    output logic [DATA_W-1:0] mul_a,
    output logic [DATA_W-1:0] mul_b,
    output logic              alu_go,
    output logic [TAG_W-1:0]  alu_dst,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b
);
    localparam int MAT_W = NUM_ST * NUM_ST;

    rs_op_t            new_op;
    rs_state_e         st_state [NUM_ST];
    logic              st_mul   [NUM_ST];
    logic [TAG_W-1:0]  st_dst   [NUM_ST];
    logic [DATA_W-1:0] st_a     [NUM_ST];
    logic [DATA_W-1:0] st_b     [NUM_ST];

    logic [NUM_ST-1:0] cand_mul, cand_alu, win_mul, win_alu, pick;
    logic [NUM_ST-1:0] avail, occupied, slot_oh, alloc;
    logic [MAT_W-1:0]  older_flat;
    logic              found;

    always_comb begin
        new_op.is_mul = iss_mul;
        new_op.dst    = iss_dst;
        new_op.a      = '{rdy: iss_a_rdy, tag: iss_a_tag, val: iss_a_val};
        new_op.b      = '{rdy: iss_b_rdy, tag: iss_b_tag, val: iss_b_val};
    end

    for (genvar i = 0; i < NUM_ST; i++) begin : g_st
        rs_station u_st (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc[i]),
            .alloc_op (new_op),
            .pick     (pick[i]),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .state    (st_state[i]),
            .is_mul   (st_mul[i]),
            .dst      (st_dst[i]),
            .a_val    (st_a[i]),
            .b_val    (st_b[i])
        );
        assign cand_mul[i] = (st_state[i] == ST_READY) && st_mul[i] && mul_idle;
        assign cand_alu[i] = (st_state[i] == ST_READY) && !st_mul[i];
        assign occupied[i] = (st_state[i] != ST_FREE);
        assign avail[i]    = !occupied[i] || pick[i];
    end

    rs_age_matrix #(.NUM_ST(NUM_ST)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (alloc),
        .older_flat (older_flat)
    );

    rs_oldest_pick #(.NUM_ST(NUM_ST)) u_pick_mul (
        .cand       (cand_mul),
        .older_flat (older_flat),
        .win        (win_mul)
    );

    rs_oldest_pick #(.NUM_ST(NUM_ST)) u_pick_alu (
        .cand       (cand_alu),
        .older_flat (older_flat),
        .win        (win_alu)
    );

    assign pick = win_mul | win_alu;

    // lowest available station takes the new instruction
    always_comb begin
        slot_oh = '0;
        found   = 1'b0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (avail[i] && !found) begin
                slot_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    assign iss_ready = |avail;
    assign alloc     = iss_valid ? slot_oh : '0;
    assign pool_full = &occupied;

    // dispatch multiplexers (one-hot select)
    always_comb begin
        mul_go  = |win_mul;
        alu_go  = |win_alu;
        mul_dst = '0;
        mul_a   = '0;
        mul_b   = '0;
        alu_dst = '0;
        alu_a   = '0;
        alu_b   = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (win_mul[i]) begin
                mul_dst |= st_dst[i];
                mul_a   |= st_a[i];
                mul_b   |= st_b[i];
            end
            if (win_alu[i]) begin
                alu_dst |= st_dst[i];
                alu_a   |= st_a[i];
                alu_b   |= st_b[i];
            end
        end
    end
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
    parameter int NUM_ST = 4
) (
    input logic clk,
    input logic rst_n,
    input logic iss_valid,
    input logic iss_ready,
    input logic pool_full,
    input logic mul_idle,
    input logic mul_go,
    input logic alu_go
);
    localparam int CNT_W = $clog2(NUM_ST + 1) + 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(iss_valid && iss_ready) - CNT_W'(mul_go) - CNT_W'(alu_go);
    end

    assert_idle_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (!mul_go && !alu_go && !pool_full));

    assert_stall_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == CNT_W'(NUM_ST)) && !mul_go && !alu_go) |-> !iss_ready);

    assert_full_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pool_full |-> (cnt == CNT_W'(NUM_ST)));

    assert_full_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(NUM_ST)) |-> pool_full);

    assert_mul_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |-> mul_idle);

    assert_free_on_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_go || alu_go) |-> iss_ready);
endmodule

bind rs_sched rs_sched_chk #(.NUM_ST(NUM_ST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .pool_full (pool_full),
    .mul_idle  (mul_idle),
    .mul_go    (mul_go),
    .alu_go    (alu_go)
);

// File: tb/tb_rs_sched.sv
`timescale 1ns/100ps
module tb_rs_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0, iss_ready, iss_mul = 1'b0;
    logic [2:0]  iss_dst = '0, iss_a_tag = '0, iss_b_tag = '0;
    logic        iss_a_rdy = 1'b0, iss_b_rdy = 1'b0;
    logic [31:0] iss_a_val = '0, iss_b_val = '0;
    logic        bc_valid = 1'b0;
    logic [2:0]  bc_tag = '0;
    logic [31:0] bc_data = '0;
    logic        pool_full, mul_idle = 1'b1;
    logic        mul_go, alu_go;
    logic [2:0]  mul_dst, alu_dst;
    logic [31:0] mul_a, mul_b, alu_a, alu_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rs_sched dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic offer(input logic m, input logic [2:0] d,
                         input logic ar, input logic [2:0] at, input logic [31:0] av,
                         input logic br, input logic [2:0] bt, input logic [31:0] bv);
        iss_valid = 1'b1; iss_mul = m; iss_dst = d;
        iss_a_rdy = ar; iss_a_tag = at; iss_a_val = av;
        iss_b_rdy = br; iss_b_tag = bt; iss_b_val = bv;
    endtask

    task automatic quiet();
        iss_valid = 1'b0;
        bc_valid  = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        settle();
        chk("R1 iss_ready", iss_ready, 1);
        chk("R1 pool_full", pool_full, 0);
        chk("R1 mul_go", mul_go, 0);
        chk("R1 alu_go", alu_go, 0);
    endtask

    task automatic t_ready_issue();
        tick(); offer(0, 3'd1, 1, 0, 32'd5, 1, 0, 32'd7); settle();
        chk("R4 no start in issue cycle", alu_go, 0);
        tick(); quiet(); settle();
        chk("R4 start next cycle", alu_go, 1);
        chk("R11 alu_dst", alu_dst, 1);
        chk("R11 alu_a", alu_a, 5);
        chk("R11 alu_b", alu_b, 7);
        tick(); settle();
        chk("R4 single start", alu_go, 0);
    endtask

    task automatic t_wakeup();
        tick(); offer(0, 3'd2, 0, 3'd5, 0, 1, 0, 32'd9); settle();
        tick(); quiet(); settle();
        chk("R5 waiting", alu_go, 0);
        tick(); bc_valid = 1'b1; bc_tag = 3'd5; bc_data = 32'd100; settle();
        chk("R5 not in broadcast cycle", alu_go, 0);
        tick(); quiet(); settle();
        chk("R5 start after broadcast", alu_go, 1);
        chk("R5 captured value", alu_a, 100);
        chk("R11 alu_b", alu_b, 9);
        tick(); settle();
    endtask

    task automatic t_issue_bcast();
        tick(); offer(0, 3'd3, 0, 3'd6, 0, 1, 0, 32'd1);
        bc_valid = 1'b1; bc_tag = 3'd6; bc_data = 32'd55; settle();
        tick(); quiet(); settle();
        chk("R6 start", alu_go, 1);
        chk("R6 value", alu_a, 55);
        tick(); settle();
    endtask

    task automatic t_age_order();
        tick(); offer(0, 3'd4, 0, 3'd2, 0, 1, 0, 32'd1); settle();
        tick(); offer(0, 3'd5, 0, 3'd3, 0, 1, 0, 32'd1); settle();
        tick(); offer(0, 3'd6, 0, 3'd2, 0, 1, 0, 32'd1); settle();
        tick(); quiet(); bc_valid = 1'b1; bc_tag = 3'd3; bc_data = 32'd30; settle();
        chk("R5 no start", alu_go, 0);
        tick(); quiet(); offer(0, 3'd7, 0, 3'd2, 0, 1, 0, 32'd1); settle();
        chk("R5 woken start", alu_go, 1);
        chk("R5 woken dst", alu_dst, 5);
        chk("R9 refill ready", iss_ready, 1);
        tick(); quiet(); bc_valid = 1'b1; bc_tag = 3'd2; bc_data = 32'd20; settle();
        chk("R5 no start", alu_go, 0);
        tick(); quiet(); settle();
        chk("R7 first oldest", alu_dst, 4);
        chk("R7 first value", alu_a, 20);
        tick(); settle();
        chk("R7 second oldest", alu_dst, 6);
        tick(); settle();
        chk("R7 youngest last", alu_dst, 7);
        chk("R7 go", alu_go, 1);
        tick(); settle();
        chk("R7 drained", alu_go, 0);
    endtask

    task automatic t_mul_gate();
        tick(); mul_idle = 1'b0; offer(1, 3'd1, 1, 0, 32'd3, 1, 0, 32'd4); settle();
        tick(); offer(0, 3'd2, 1, 0, 32'd8, 1, 0, 32'd9); settle();
        chk("R8 held while busy", mul_go, 0);
        tick(); quiet(); mul_idle = 1'b1; settle();
        chk("R8 start when idle", mul_go, 1);
        chk("R11 mul_dst", mul_dst, 1);
        chk("R11 mul_a", mul_a, 3);
        chk("R11 mul_b", mul_b, 4);
        chk("R10 both units", alu_go, 1);
        chk("R10 alu dst", alu_dst, 2);
        tick(); settle();
        chk("R10 drained", mul_go | alu_go, 0);
    endtask

    task automatic t_full_refill();
        mul_idle = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick(); offer(1, 3'(k), 1, 0, 32'(k), 1, 0, 32'(k + 1)); settle();
        end
        tick(); offer(0, 3'd4, 1, 0, 32'd77, 1, 0, 32'd78); settle();
        chk("R3 full with multiplies", pool_full, 1);
        chk("R2 stall when full", iss_ready, 0);
        tick(); mul_idle = 1'b1; offer(0, 3'd5, 1, 0, 32'd11, 1, 0, 32'd12); settle();
        chk("R9 ready on pick", iss_ready, 1);
        chk("R7 oldest multiply", mul_dst, 0);
        chk("R9 mul_go", mul_go, 1);
        tick(); quiet(); mul_idle = 1'b0; settle();
        chk("R9 refilled full", pool_full, 1);
        chk("R9 newcomer starts", alu_go, 1);
        chk("R9 newcomer dst", alu_dst, 5);
        chk("R9 newcomer value", alu_a, 11);
        for (int k = 1; k < 4; k++) begin
            tick(); mul_idle = 1'b1; settle();
            chk("R7 multiply order", mul_dst, 3'(k));
            chk("R2 dropped offer never starts", alu_go, 0);
        end
        tick(); settle();
        chk("R3 empty again", pool_full, 0);
        chk("R8 no start", mul_go, 0);
        chk("R2 dropped offer absent", alu_go, 0);
    endtask

    initial begin
        t_reset();
        t_ready_issue();
        t_wakeup();
        t_issue_bcast();
        t_age_order();
        t_mul_gate();
        t_full_refill();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule